// File: doc/BRIEF.md
# Count-to-Limit Interval Timer

This block is a programmable interval timer with a counter of configurable width (32 bits by default). It is programmed through a simple single-cycle register port that can write and read three registers: a running count, a terminal limit and a two-bit control word. When the timer is running, the count rises by one on every clock until it equals the limit. On the next clock it returns to zero and, if interrupts are armed, it raises a level interrupt.

Software uses the same hardware in three ways. A repeating tick comes from leaving the limit fixed and acknowledging each interrupt with interrupts still armed. A single delay comes from loading a short limit, zeroing the count and then disarming after the first interrupt. A free-running timestamp comes from an all-ones limit with interrupts off.

A control bit and an external debug-halt input can each freeze the count, so a debugger can stop time while the core is paused.

Top module: `ival_timer`

## Requirements
- R1: After reset the count reads 0, the limit reads all ones, the control word reads 0 and `irq` is low.
- R2: Register index 0x21 selects the count, 0x22 the control word and 0x23 the limit, for both writes and reads. A read of any other index returns 0, and a write to any other index changes no register.
- R3: While control bit 1 (run) is set and `debug_halt` is low, the count increases by exactly one per clock when it is below the limit.
- R4: While control bit 1 is clear or `debug_halt` is high, the count keeps its value.
- R5: When the timer is running and the count equals the limit, the count becomes 0 on the next clock edge.
- R6: If control bit 0 (interrupt enable) is set when the count reloads, the pending flag sets on that same edge. `irq` follows the pending flag, and control bit 3 reads it back. Bit 2 reads as 0.
- R7: Any write to the control register clears the pending flag on its edge, whatever value is written. The one exception is a reload with interrupts armed in that same cycle, which sets the flag, so a new event is never lost.
- R8: A reload while control bit 0 is clear leaves `irq` low.
- R9: With the limit at all ones, the count passes from all ones to 0 and continues upward without raising `irq` while interrupts are off.
- R10: A write to the count loads the written value on the next edge. It takes priority over increment and reload, and it produces no reload event in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe for this cycle |
| addr | input | AW | Register index for read and write |
| wdata | input | W | Write data |
| rdata | output | W | Read data for `addr`, combinational |
| debug_halt | input | 1 | Freezes the count while high |
| irq | output | 1 | Level interrupt, high while the pending flag is set |

## Verification
The counter is tried with a small limit and interrupts armed, which separates a correct reload-to-zero from an off-by-one in the terminal compare. The same limit with interrupts disarmed and with an acknowledge that only keeps the run bit tells apart clearing the flag from re-arming it. An all-ones limit started just below the top shows the wrap with no interrupt. A control write placed in the same cycle as a reload, and a count write placed on the limit, expose the two priority orders. A long stretch of mixed random writes, halts and small limits is followed against the model on every clock.

// File: rtl/ival_timer_pkg.sv
package ival_timer_pkg;

    // Register indices decoded on the register port
    localparam int IDX_COUNT = 32'h21;
    localparam int IDX_CTRL  = 32'h22;
    localparam int IDX_LIMIT = 32'h23;

    // Bit positions inside the control word as read back
    localparam int BIT_IE   = 0;
    localparam int BIT_RUN  = 1;
    localparam int BIT_PEND = 3;

    // Writable control state; packed so bit 1 is run and bit 0 is enable
    typedef struct packed {
        logic run;
        logic ie;
    } ctrl_t;

endpackage

// File: rtl/ival_timer_count.sv
module ival_timer_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         cnt_wr,
    input  logic         lim_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic [W-1:0] lim,
    output logic         hit
);
    localparam logic [W-1:0] LIM_RST = '1;
    localparam logic [W-1:0] ONE     = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] lim;
    } st_t;

    st_t  st_d, st_q;
    logic at_lim;

    always_comb begin
        st_d   = st_q;
        at_lim = (st_q.cnt == st_q.lim);
        hit    = run & ~cnt_wr & at_lim;
        if (cnt_wr) begin
            st_d.cnt = wdata;
        end else if (run) begin
            st_d.cnt = at_lim ? '0 : st_q.cnt + ONE;
        end
        if (lim_wr) begin
            st_d.lim = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, lim: LIM_RST};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign lim = st_q.lim;

endmodule

// File: rtl/ival_timer_ctrl.sv
module ival_timer_ctrl
    import ival_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] wbits,
    input  logic       hit,
    output ctrl_t      ctrl,
    output logic       pend
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a reload with interrupts armed wins over an acknowledge
        st_d.pend = (hit & st_q.ctrl.ie) | (st_q.pend & ~ctrl_wr);
        if (ctrl_wr) begin
            st_d.ctrl = ctrl_t'(wbits);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl = st_q.ctrl;
    assign pend = st_q.pend;

endmodule

// File: rtl/ival_timer_rdmux.sv
module ival_timer_rdmux
    import ival_timer_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  cnt,
    input  logic [W-1:0]  lim,
    input  ctrl_t         ctrl,
    input  logic          pend,
    output logic [W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        if (addr == AW'(IDX_COUNT)) begin
            rdata = cnt;
        end else if (addr == AW'(IDX_LIMIT)) begin
            rdata = lim;
        end else if (addr == AW'(IDX_CTRL)) begin
            rdata[BIT_IE]   = ctrl.ie;
            rdata[BIT_RUN]  = ctrl.run;
            rdata[BIT_PEND] = pend;
        end
    end

endmodule

// File: rtl/ival_timer.sv
module ival_timer
    import ival_timer_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic          debug_halt,
    output logic          irq
);
    logic         cnt_wr, lim_wr, ctrl_wr;
    logic         run, hit, pend_q;
    logic [W-1:0] cnt_q, lim_q;
    ctrl_t        ctrl_q;

    assign cnt_wr  = wr_en && (addr == AW'(IDX_COUNT));
    assign lim_wr  = wr_en && (addr == AW'(IDX_LIMIT));
    assign ctrl_wr = wr_en && (addr == AW'(IDX_CTRL));
    assign run     = ctrl_q.run & ~debug_halt;

    ival_timer_count #(.W(W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .cnt_wr (cnt_wr),
        .lim_wr (lim_wr),
        .wdata  (wdata),
        .cnt    (cnt_q),
        .lim    (lim_q),
        .hit    (hit)
    );

    ival_timer_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wbits   (wdata[1:0]),
        .hit     (hit),
        .ctrl    (ctrl_q),
        .pend    (pend_q)
    );

    ival_timer_rdmux #(.W(W), .AW(AW)) u_rdmux (
        .addr  (addr),
        .cnt   (cnt_q),
        .lim   (lim_q),
        .ctrl  (ctrl_q),
        .pend  (pend_q),
        .rdata (rdata)
    );

    assign irq = pend_q;

endmodule

// File: rtl/ival_timer_chk.sv
module ival_timer_chk
    import ival_timer_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [W-1:0]  wdata,
    input logic          debug_halt,
    input logic          irq,
    input logic [W-1:0]  cnt,
    input logic [W-1:0]  lim,
    input logic          ie,
    input logic          run_bit
);
    logic cw, kw, going, at_lim, fire;

    assign cw     = wr_en && (addr == AW'(IDX_COUNT));
    assign kw     = wr_en && (addr == AW'(IDX_CTRL));
    assign going  = run_bit && !debug_halt;
    assign at_lim = (cnt == lim);
    assign fire   = going && !cw && at_lim && ie;

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!going && !cw) |=> (cnt == $past(cnt)));                   // R4
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (going && !cw && !at_lim) |=> (cnt == $past(cnt) + W'(1)));  // R3
    AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (going && !cw && at_lim) |=> (cnt == '0));                  // R5
    AST_IRQ_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> irq);                                              // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (kw && !fire) |=> !irq);                                    // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !fire) |=> !irq);                                  // R8
    AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cw |=> (cnt == $past(wdata)));                              // R10

endmodule

bind ival_timer ival_timer_chk #(.W(W), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .debug_halt (debug_halt),
    .irq        (irq),
    .cnt        (cnt_q),
    .lim        (lim_q),
    .ie         (ctrl_q.ie),
    .run_bit    (ctrl_q.run)
);

// File: tb/ival_timer_test.sv
`timescale 1ns/1ps
module ival_timer_test;
    localparam int W  = 32;
    localparam int AW = 8;
    localparam logic [AW-1:0] A_CNT = 8'h21;
    localparam logic [AW-1:0] A_CTL = 8'h22;
    localparam logic [AW-1:0] A_LIM = 8'h23;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic          debug_halt = 1'b0;
    logic [W-1:0]  rdata;
    logic          irq;

    always #4 clk = ~clk;

    ival_timer #(.W(W), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .debug_halt(debug_halt), .irq(irq)
    );

    int checks = 0;
    int failures = 0;
    logic [W-1:0] last_rd;
    logic         last_irq;

    // behavioural reference state
    logic [W-1:0] m_cnt = '0;
    logic [W-1:0] m_lim = '1;
    logic         m_ie = 1'b0, m_nh = 1'b0, m_pend = 1'b0;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] m_read(input logic [AW-1:0] a);
        logic [W-1:0] v;
        v = '0;
        if (a == A_CNT) v = m_cnt;
        else if (a == A_LIM) v = m_lim;
        else if (a == A_CTL) begin v[0] = m_ie; v[1] = m_nh; v[3] = m_pend; end
        return v;
    endfunction

    // one clock: drive at falling edge, compare to model, advance model at rising edge
    task automatic cyc(input string tag, input logic w, input logic [AW-1:0] a,
                       input logic [W-1:0] d, input logic h);
        logic run, hit, cw, kw;
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; debug_halt = h;
        #2;
        last_rd  = rdata;
        last_irq = irq;
        chk({tag, " model rdata"}, rdata, m_read(a));
        chk({tag, " model irq"}, W'(irq), W'(m_pend));
        @(posedge clk);
        cw  = w && (a == A_CNT);
        kw  = w && (a == A_CTL);
        run = m_nh && !h;
        hit = run && !cw && (m_cnt == m_lim);
        m_pend = (hit && m_ie) || (m_pend && !kw);
        if (cw) m_cnt = d;
        else if (run) m_cnt = hit ? '0 : m_cnt + 1;
        if (w && a == A_LIM) m_lim = d;
        if (kw) begin m_ie = d[0]; m_nh = d[1]; end
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a, input logic [W-1:0] exp, input logic h);
        cyc(tag, 1'b0, a, '0, h);
        chk(tag, last_rd, exp);
    endtask

    task automatic wr(input string tag, input logic [AW-1:0] a, input logic [W-1:0] d);
        cyc(tag, 1'b1, a, d, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd("R1 count", A_CNT, 32'h0, 1'b0);
        rd("R1 ctrl", A_CTL, 32'h0, 1'b0);
        rd("R1 limit", A_LIM, 32'hFFFF_FFFF, 1'b0);
        chk("R1 irq", W'(last_irq), '0);

        // R2 index decode
        wr("R2 wr limit", A_LIM, 32'd5);
        rd("R2 limit", A_LIM, 32'd5, 1'b0);
        wr("R2 wr other", 8'h20, 32'h123);
        rd("R2 limit kept", A_LIM, 32'd5, 1'b0);
        rd("R2 count kept", A_CNT, 32'd0, 1'b0);
        rd("R2 other reads 0", 8'h24, 32'd0, 1'b0);

        // R4 halted by control bit
        wr("R4 wr count", A_CNT, 32'd7);
        rd("R4 hold a", A_CNT, 32'd7, 1'b0);
        rd("R4 hold b", A_CNT, 32'd7, 1'b0);

        // R3 increment
        wr("R3 run", A_CTL, 32'h2);
        rd("R3 step a", A_CNT, 32'd7, 1'b0);
        rd("R3 step b", A_CNT, 32'd8, 1'b0);
        rd("R3 step c", A_CNT, 32'd9, 1'b0);
        // R4 debug halt
        rd("R4 dbg a", A_CNT, 32'd10, 1'b1);
        rd("R4 dbg b", A_CNT, 32'd10, 1'b1);
        rd("R4 dbg c", A_CNT, 32'd10, 1'b0);
        rd("R3 resume", A_CNT, 32'd11, 1'b0);

        // R5 and R6 reload with interrupt
        wr("R5 zero", A_CNT, 32'd0);
        wr("R6 arm", A_CTL, 32'h3);
        for (int i = 1; i <= 5; i++) rd("R5 climb", A_CNT, W'(i), 1'b0);
        rd("R6 pend bit", A_CTL, 32'hB, 1'b0);
        chk("R6 irq high", W'(last_irq), W'(1));
        chk("R5 reloaded", m_read(A_CNT), W'(1));

        // R7 acknowledge with re-arm
        wr("R7 ack", A_CTL, 32'h3);
        rd("R7 cleared", A_CTL, 32'h3, 1'b0);
        chk("R7 irq low", W'(last_irq), '0);

        // R8 silenced
        wr("R8 silence", A_CTL, 32'h2);
        for (int i = 0; i < 9; i++) cyc("R8 idle", 1'b0, A_CTL, '0, 1'b0);
        chk("R8 irq low", W'(last_irq), '0);
        rd("R8 ctrl", A_CTL, 32'h2, 1'b0);

        // R7 reload coinciding with control write
        wr("R7 arm", A_CTL, 32'h3);
        wr("R7 zero", A_CNT, 32'd0);
        for (int i = 0; i < 5; i++) rd("R7 climb", A_CNT, W'(i), 1'b0);
        wr("R7 ack at hit", A_CTL, 32'h3);
        rd("R7 event kept", A_CTL, 32'hB, 1'b0);

        // R9 free-running wrap
        wr("R9 limit", A_LIM, 32'hFFFF_FFFF);
        wr("R9 ctrl", A_CTL, 32'h2);
        wr("R9 count", A_CNT, 32'hFFFF_FFFD);
        rd("R9 a", A_CNT, 32'hFFFF_FFFD, 1'b0);
        rd("R9 b", A_CNT, 32'hFFFF_FFFE, 1'b0);
        rd("R9 c", A_CNT, 32'hFFFF_FFFF, 1'b0);
        rd("R9 wrap", A_CNT, 32'h0, 1'b0);
        rd("R9 after", A_CNT, 32'h1, 1'b0);
        chk("R9 irq low", W'(last_irq), '0);

        // R10 count write beats reload
        wr("R10 limit", A_LIM, 32'd4);
        wr("R10 arm", A_CTL, 32'h3);
        wr("R10 load", A_CNT, 32'd4);
        wr("R10 load at limit", A_CNT, 32'd9);
        rd("R10 loaded", A_CNT, 32'd9, 1'b0);
        chk("R10 no irq", W'(last_irq), '0);

        // mixed traffic checked against the model every clock (R3 R4 R5 R6 R7)
        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            logic [AW-1:0] a;
            r = $urandom;
            a = A_CNT + AW'(r % 4);
            if (a > A_LIM) a = 8'h30;
            cyc("R3 R5 R6 R7 mixed", (r[7:4] == 4'd0), a, W'(r[15:12]), r[19:17] == 3'd0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule